// File: doc/BRIEF.md
# Factory Bad Block Scanner

This block runs once on a NAND device straight from the factory, before any program or erase is allowed. It builds a table of bad blocks. It walks the device one block at a time, in ascending order. For each block it reads the spare area of the first two pages through a simple read interface. A request carries a block, a page and a starting column, and the memory answers with a stream of bytes, each marked by a valid strobe.

A block counts as bad when any spare byte it examines is not FFh. A factory mark of 00h is the usual case of a bad byte. Once page 0 has shown a bad byte, the scanner skips the read of page 1 for that block.

The results are a bitmap with one bit per block, a running count of bad blocks, a one-cycle done pulse and a level that stays high once the scan is complete. Program or erase requests from the rest of the controller pass through a gate in this block. The gate refuses them until the scan is complete.

Top module: `bbs_scanner`

## Requirements
- R1: After reset, `bad_map` and `bad_count` are zero, `scan_done`, `scan_complete` and `scan_busy` are low, and no read request is raised until `start` is seen.
- R2: After `start`, read requests cover the blocks in ascending order from block 0, and within a block page 0 comes before page 1. Every request carries column `DATA_BYTES` (2048 by default), the first spare column. The memory then returns exactly `SPARE_BYTES` bytes, each on a cycle with `rd_data_valid` high.
- R3: Bit b of `bad_map` is 1 exactly when some examined spare byte of block b differs from FFh. A byte of 00h marks the block bad, and so does any other value that is not FFh.
- R4: Only pages 0 and 1 are read. Page 1 of a block is requested only when all spare bytes of its page 0 were FFh. The remaining bytes of a page already requested are still taken in.
- R5: `bad_count` equals the number of 1 bits in `bad_map` and never exceeds `NUM_BLOCKS`.
- R6: `scan_done` is high for exactly one cycle, the cycle after the last block is recorded. From that cycle on, `scan_complete` stays high and `bad_map` and `bad_count` do not change.
- R7: A cycle with `pe_req` high while the scan is not complete produces `pe_reject` high and `pe_grant` low in the next cycle. After completion it produces `pe_grant` high and `pe_reject` low.
- R8: `start` has no effect while a scan is running or after it has completed. No new requests are issued and the results are unchanged.
- R9: `rd_req_valid` is held, with `rd_req_block`, `rd_req_page` and `rd_req_col` stable, until the cycle in which `rd_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the one-time scan |
| rd_req_valid | output | 1 | Read request pending |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_block | output | 11 | Block to read |
| rd_req_page | output | 6 | Page within the block (0 or 1) |
| rd_req_col | output | 12 | Starting column (first spare byte) |
| rd_data_valid | input | 1 | Returned byte strobe |
| rd_data | input | 8 | Returned byte |
| pe_req | input | 1 | Program or erase request from the controller |
| pe_grant | output | 1 | Request allowed (scan complete) |
| pe_reject | output | 1 | Request refused (scan not complete) |
| bad_map | output | 2048 | One bit per block, 1 = bad |
| bad_count | output | 12 | Number of bad blocks found |
| scan_done | output | 1 | One-cycle pulse at the end of the scan |
| scan_complete | output | 1 | High from the end of the scan until reset |
| scan_busy | output | 1 | Scan in progress |

## Verification
Some internal faults show up quickly. A lost page index or a wrong early-stop decision shows at the read port within one request: a page 1 read that should have been skipped, a missing page 1 read, or blocks out of order. A stale bad flag, or one cleared at the wrong moment, shows up differently. It corrupts the bitmap bit of the next block in the cycle that block is recorded. It also shifts `bad_count` from the number of set bits at the same edge. A fault in the completion state shows within one cycle at the program/erase gate and in the width of `scan_done`.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
    // Value of an unmarked spare byte on a fresh device
    localparam logic [7:0] MARK_CLEAN = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_COMMIT,
        ST_DONE
    } scan_state_e;
endpackage

// File: rtl/bbs_marker_check.sv
module bbs_marker_check
    import bbs_pkg::*;
#(
    parameter int SPARE_BYTES = 64,
    localparam int IDX_W = (SPARE_BYTES > 1) ? $clog2(SPARE_BYTES) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       block_clear,
    input  logic       beat_valid,
    input  logic [7:0] beat_data,
    output logic       last_beat,
    output logic       block_bad
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             bad;
    } chk_t;

    chk_t cur_q, nxt_d;
    logic byte_bad;

    always_comb begin
        nxt_d     = cur_q;
        byte_bad  = beat_valid && (beat_data != MARK_CLEAN);
        last_beat = beat_valid && (cur_q.idx == IDX_W'(SPARE_BYTES - 1));
        block_bad = cur_q.bad | byte_bad;
        if (block_clear) begin
            nxt_d.bad = 1'b0;
            nxt_d.idx = '0;
        end else if (beat_valid) begin
            nxt_d.bad = block_bad;
            if (last_beat) nxt_d.idx = '0;
            else           nxt_d.idx = cur_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/bbs_bad_map.sv
module bbs_bad_map #(
    parameter int NUM_BLOCKS = 2048,
    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [BLK_W-1:0]      wr_idx,
    input  logic                  wr_bad,
    output logic [NUM_BLOCKS-1:0] map,
    output logic [CNT_W-1:0]      count
);
    typedef struct packed {
        logic [NUM_BLOCKS-1:0] bits;
        logic [CNT_W-1:0]      cnt;
    } map_t;

    map_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wr_en && wr_bad) begin
            for (int b = 0; b < NUM_BLOCKS; b++) begin
                if (wr_idx == BLK_W'(b)) nxt_d.bits[b] = 1'b1;
            end
            if (cur_q.cnt < CNT_W'(NUM_BLOCKS)) nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign map   = cur_q.bits;
    assign count = cur_q.cnt;
endmodule

// File: rtl/bbs_pe_gate.sv
module bbs_pe_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pe_req,
    input  logic scan_complete,
    output logic pe_grant,
    output logic pe_reject
);
    typedef struct packed {
        logic grant;
        logic reject;
    } gate_t;

    gate_t cur_q, nxt_d;

    always_comb begin
        nxt_d.grant  = pe_req &&  scan_complete;
        nxt_d.reject = pe_req && !scan_complete;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pe_grant  = cur_q.grant;
    assign pe_reject = cur_q.reject;
endmodule

// File: rtl/bbs_scanner.sv
module bbs_scanner
    import bbs_pkg::*;
#(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int DATA_BYTES      = 2048,
    parameter int SPARE_BYTES     = 64,
    localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int PAGE_W = (PAGES_PER_BLOCK > 2) ? $clog2(PAGES_PER_BLOCK) : 1,
    localparam int COL_W  = $clog2(DATA_BYTES + SPARE_BYTES),
    localparam int CNT_W  = $clog2(NUM_BLOCKS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  rd_req_valid,
    input  logic                  rd_req_ready,
    output logic [BLK_W-1:0]      rd_req_block,
    output logic [PAGE_W-1:0]     rd_req_page,
    output logic [COL_W-1:0]      rd_req_col,
    input  logic                  rd_data_valid,
    input  logic [7:0]            rd_data,
    input  logic                  pe_req,
    output logic                  pe_grant,
    output logic                  pe_reject,
    output logic [NUM_BLOCKS-1:0] bad_map,
    output logic [CNT_W-1:0]      bad_count,
    output logic                  scan_done,
    output logic                  scan_complete,
    output logic                  scan_busy
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    typedef struct packed {
        scan_state_e      st;
        logic [BLK_W-1:0] blk;
        logic             pg;
        logic             done_p;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic beat_valid;
    logic last_beat;
    logic block_bad;
    logic block_clear;
    logic map_wr;

    bbs_marker_check #(.SPARE_BYTES(SPARE_BYTES)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .block_clear (block_clear),
        .beat_valid  (beat_valid),
        .beat_data   (rd_data),
        .last_beat   (last_beat),
        .block_bad   (block_bad)
    );

    bbs_bad_map #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (map_wr),
        .wr_idx (ctl_q.blk),
        .wr_bad (block_bad),
        .map    (bad_map),
        .count  (bad_count)
    );

    bbs_pe_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .pe_req        (pe_req),
        .scan_complete (scan_complete),
        .pe_grant      (pe_grant),
        .pe_reject     (pe_reject)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.done_p = 1'b0;
        block_clear  = 1'b0;
        map_wr       = 1'b0;
        beat_valid   = rd_data_valid && (ctl_q.st == ST_WAIT);
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st    = ST_REQ;
                    ctl_d.blk   = '0;
                    ctl_d.pg    = 1'b0;
                    block_clear = 1'b1;
                end
            end
            ST_REQ: begin
                if (rd_req_ready) ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (last_beat) begin
                    // early stop: a bad page 0 skips the page 1 read
                    if (block_bad || ctl_q.pg) begin
                        ctl_d.st = ST_COMMIT;
                    end else begin
                        ctl_d.pg = 1'b1;
                        ctl_d.st = ST_REQ;
                    end
                end
            end
            ST_COMMIT: begin
                map_wr      = 1'b1;
                block_clear = 1'b1;
                if (ctl_q.blk == LAST_BLK) begin
                    ctl_d.st     = ST_DONE;
                    ctl_d.done_p = 1'b1;
                end else begin
                    ctl_d.blk = ctl_q.blk + 1'b1;
                    ctl_d.pg  = 1'b0;
                    ctl_d.st  = ST_REQ;
                end
            end
            ST_DONE: ctl_d.st = ST_DONE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_IDLE;
            ctl_q.blk    <= '0;
            ctl_q.pg     <= 1'b0;
            ctl_q.done_p <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_req_valid  = (ctl_q.st == ST_REQ);
    assign rd_req_block  = ctl_q.blk;
    assign rd_req_page   = PAGE_W'(ctl_q.pg);
    assign rd_req_col    = COL_W'(DATA_BYTES);
    assign scan_done     = ctl_q.done_p;
    assign scan_complete = (ctl_q.st == ST_DONE);
    assign scan_busy     = (ctl_q.st == ST_REQ) || (ctl_q.st == ST_WAIT) ||
                           (ctl_q.st == ST_COMMIT);
endmodule

// File: rtl/bbs_scanner_chk.sv
module bbs_scanner_chk #(
    parameter int NUM_BLOCKS = 2048,
    parameter int BLK_W      = 11,
    parameter int PAGE_W     = 6,
    parameter int COL_W      = 12,
    parameter int CNT_W      = 12,
    parameter int DATA_BYTES = 2048
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_req_valid,
    input logic                  rd_req_ready,
    input logic [BLK_W-1:0]      rd_req_block,
    input logic [PAGE_W-1:0]     rd_req_page,
    input logic [COL_W-1:0]      rd_req_col,
    input logic                  pe_req,
    input logic                  pe_grant,
    input logic                  pe_reject,
    input logic [NUM_BLOCKS-1:0] bad_map,
    input logic [CNT_W-1:0]      bad_count,
    input logic                  scan_done,
    input logic                  scan_complete,
    input logic                  scan_busy
);
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_busy) |-> !rd_req_valid);

    a_r2_spare_col: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_col == COL_W'(DATA_BYTES)));

    a_r4_first_two_pages: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_page <= PAGE_W'(1)));

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bad_count <= CNT_W'(NUM_BLOCKS));

    a_r5_count_matches_map: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bad_map) == int'(bad_count));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    a_r6_done_complete: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> scan_complete);

    a_r6_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        scan_complete |=> (scan_complete && $stable(bad_map) && $stable(bad_count)));

    a_r7_reject_early: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_req && !scan_complete) |=> (pe_reject && !pe_grant));

    a_r7_grant_late: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_req && scan_complete) |=> (pe_grant && !pe_reject));

    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        scan_complete |=> !scan_busy);

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=>
            (rd_req_valid && $stable(rd_req_block) && $stable(rd_req_page)));
endmodule

bind bbs_scanner bbs_scanner_chk #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLK_W      (BLK_W),
    .PAGE_W     (PAGE_W),
    .COL_W      (COL_W),
    .CNT_W      (CNT_W),
    .DATA_BYTES (DATA_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_req_block  (rd_req_block),
    .rd_req_page   (rd_req_page),
    .rd_req_col    (rd_req_col),
    .pe_req        (pe_req),
    .pe_grant      (pe_grant),
    .pe_reject     (pe_reject),
    .bad_map       (bad_map),
    .bad_count     (bad_count),
    .scan_done     (scan_done),
    .scan_complete (scan_complete),
    .scan_busy     (scan_busy)
);

// File: tb/tb_bbs_scanner.sv
module tb_bbs_scanner;
    localparam int NB   = 16;
    localparam int PPB  = 64;
    localparam int DB   = 2048;
    localparam int SP   = 8;
    localparam int BW   = $clog2(NB);
    localparam int PW   = $clog2(PPB);
    localparam int CW   = $clog2(DB + SP);
    localparam int NW   = $clog2(NB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_req_valid;
    logic          rd_req_ready = 1'b0;
    logic [BW-1:0] rd_req_block;
    logic [PW-1:0] rd_req_page;
    logic [CW-1:0] rd_req_col;
    logic          rd_data_valid = 1'b0;
    logic [7:0]    rd_data = 8'h00;
    logic          pe_req = 1'b0;
    logic          pe_grant, pe_reject;
    logic [NB-1:0] bad_map;
    logic [NW-1:0] bad_count;
    logic          scan_done, scan_complete, scan_busy;

    bbs_scanner #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .DATA_BYTES(DB),
                  .SPARE_BYTES(SP)) dut (.*);

    always #10 clk = ~clk;   // 50 MHz

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0] mem [NB][2][SP];
    int log_blk [256];
    int log_pg  [256];
    int log_n;
    int done_cnt;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit page_clean(input int b, input int p);
        for (int i = 0; i < SP; i++) if (mem[b][p][i] != 8'hFF) return 0;
        return 1;
    endfunction

    function automatic bit exp_bad(input int b);
        return !(page_clean(b, 0) && page_clean(b, 1));
    endfunction

    // Memory responder, drives at falling edges
    initial begin
        logic acc_pend;
        logic streaming;
        int   idx, cb, cp;
        acc_pend = 0; streaming = 0; idx = 0; cb = 0; cp = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                acc_pend = 0; streaming = 0;
                rd_req_ready = 0; rd_data_valid = 0;
            end else if (streaming) begin
                if (idx < SP) begin
                    if ($urandom % 4 != 0) begin
                        rd_data_valid = 1; rd_data = mem[cb][cp][idx]; idx++;
                    end else begin
                        rd_data_valid = 0; rd_data = 8'hFF;
                    end
                end else begin
                    rd_data_valid = 0; streaming = 0;
                end
            end else if (acc_pend) begin
                acc_pend = 0; rd_req_ready = 0; streaming = 1; idx = 0;
                if (log_n < 256) begin
                    log_blk[log_n] = cb; log_pg[log_n] = cp;
                end
                log_n++;
            end else begin
                rd_req_ready = rd_req_valid ? 1'($urandom % 2) : 1'b0;
                if (rd_req_valid && rd_req_ready) begin
                    acc_pend = 1;
                    cb = int'(rd_req_block);
                    cp = (rd_req_page > 1) ? 1 : int'(rd_req_page);
                    chk(rd_req_col == CW'(DB), "R2 column", int'(rd_req_col), DB);
                    chk(rd_req_page <= 1, "R4 page range", int'(rd_req_page), 1);
                end
            end
        end
    end

    initial forever begin
        @(negedge clk);
        if (rst_n && scan_done) done_cnt++;
    end

    task automatic fill(input int kind);
        for (int b = 0; b < NB; b++) begin
            int r;
            for (int p = 0; p < 2; p++)
                for (int i = 0; i < SP; i++) mem[b][p][i] = 8'hFF;
            r = (kind == 0) ? 0 : (kind == 1) ? 2 : int'($urandom % 5);
            case (r)
                2: mem[b][0][(kind == 1) ? 0 : int'($urandom % SP)] = 8'h00;
                3: mem[b][1][$urandom % SP] = 8'($urandom % 255);
                4: mem[b][0][SP-1] = 8'hFE;
                default: ;
            endcase
        end
    endtask

    task automatic pulse_pe(input bit expect_grant, input string req);
        pe_req = 1;
        @(negedge clk);
        pe_req = 0;
        chk(pe_grant == expect_grant && pe_reject == !expect_grant, req,
            {30'd0, pe_grant, pe_reject}, expect_grant ? 2 : 1);
    endtask

    task automatic run_trial(input int kind, input bit poke_start);
        int cyc, exp_cnt, n, nlog;
        logic [NB-1:0] snap;
        fill(kind);
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        log_n = 0; done_cnt = 0;
        rst_n = 1;
        @(negedge clk);
        chk(bad_map == '0 && bad_count == 0, "R1 reset results", int'(bad_count), 0);
        chk(!scan_done && !scan_complete && !scan_busy && !rd_req_valid,
            "R1 reset flags", {28'd0, scan_done, scan_complete, scan_busy, rd_req_valid}, 0);
        pulse_pe(0, "R7 reject before start");
        start = 1; @(negedge clk); start = 0;
        repeat (5) @(negedge clk);
        pulse_pe(0, "R7 reject during scan");
        if (poke_start) begin
            start = 1; @(negedge clk); start = 0;
        end
        cyc = 0;
        while (!scan_complete && cyc < 20000) begin @(negedge clk); cyc++; end
        chk(scan_complete, "R6 scan completes", int'(scan_complete), 1);
        @(negedge clk);
        chk(done_cnt == 1, "R6 single done pulse", done_cnt, 1);
        exp_cnt = 0;
        for (int b = 0; b < NB; b++) begin
            chk(bad_map[b] == exp_bad(b), $sformatf("R3 map bit %0d", b),
                int'(bad_map[b]), int'(exp_bad(b)));
            exp_cnt += int'(exp_bad(b));
        end
        chk(int'(bad_count) == exp_cnt, "R5 bad count", int'(bad_count), exp_cnt);
        n = 0;
        for (int b = 0; b < NB; b++) begin
            chk(n < log_n && log_blk[n] == b && log_pg[n] == 0, "R2 order page0",
                (n < log_n) ? log_blk[n] * 2 + log_pg[n] : -1, b * 2);
            n++;
            if (page_clean(b, 0)) begin
                chk(n < log_n && log_blk[n] == b && log_pg[n] == 1, "R4 page1 read",
                    (n < log_n) ? log_blk[n] * 2 + log_pg[n] : -1, b * 2 + 1);
                n++;
            end
        end
        chk(log_n == n, "R4 request total", log_n, n);
        pulse_pe(1, "R7 grant after scan");
        snap = bad_map; nlog = log_n;
        start = 1; @(negedge clk); start = 0;
        repeat (30) @(negedge clk);
        chk(log_n == nlog && !scan_busy, "R8 start ignored after done", log_n, nlog);
        chk(bad_map == snap && scan_complete, "R6 map stable", int'(bad_map != snap), 0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000 && !finished) begin @(posedge clk); cyc++; end
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        log_n = 0; done_cnt = 0;
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < 2; p++)
                for (int i = 0; i < SP; i++) mem[b][p][i] = 8'hFF;
        run_trial(0, 0);          // all clean
        run_trial(1, 1);          // all factory-marked 00h, start poked mid-scan
        for (int t = 0; t < 6; t++) run_trial(2, (t % 2) == 1);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule